// File: doc/BRIEF.md
# Serial Wiper Step Engine

This block runs the fine-tuning phase of a digital potentiometer's two-wire slave. The command front end decodes an up/down stepping instruction and acknowledges it. It then pulses `step_en_i` and presents the index of the chosen pot. From that point the engine watches the synchronized bus lines. On every rising edge of the bus clock it samples the data line. A high level sends an increment stroke to the wiper register of the chosen pot. A low level sends a decrement stroke.

Stepping has no fixed length. It continues until a STOP condition appears on the bus. The wiper register lives outside this block, and the engine reads its current code on `wiper_i`. The engine holds back any stroke that would push the code past the top tap or below tap 0. The engine only listens to the bus and never drives the data line. Writing the final position into non-volatile storage is the job of other logic.

Top module: `wiper_step_engine`

## Requirements
- R1: After reset, `active_o`, `inc_o` and `dec_o` are all 0.
- R2: A cycle with `step_en_i` high sets `active_o` from the next cycle. In the same cycle it captures `pot_i` into `pot_o`. Later changes of `pot_i` leave `pot_o` unchanged.
- R3: While active, each rising edge of `scl_i` with `sda_i` high gives exactly one single-cycle `inc_o` pulse in the following cycle. Holding `scl_i` high longer adds no further pulse.
- R4: While active, each rising edge of `scl_i` with `sda_i` low gives exactly one single-cycle `dec_o` pulse in the following cycle.
- R5: Saturation. No `inc_o` is issued when `wiper_i` equals the top code (all ones, 63 by default). No `dec_o` is issued when `wiper_i` is 0. Any number of steps is accepted.
- R6: A STOP condition clears `active_o`. A STOP is `sda_i` rising while `scl_i` is high in both this cycle and the one before.
- R7: Changes of `sda_i` during a high clock period produce no stroke. In particular, a STOP placed inside the high period of a pulse adds nothing beyond that pulse's own stroke.
- R8: While `active_o` is 0, clock edges produce no strokes.
- R9: When `step_en_i` and a STOP fall in the same cycle, the enable wins. `active_o` stays 1 and `pot_o` takes the new `pot_i`.
- R10: `inc_o` and `dec_o` are never high together. A stroke appears only when the engine was active in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| step_en_i | input | 1 | One-cycle enable from the command front end |
| pot_i | input | POT_BITS | Pot index chosen by the instruction |
| wiper_i | input | TAP_BITS | Current code of the chosen wiper register |
| active_o | output | 1 | Stepping mode open |
| pot_o | output | POT_BITS | Pot index the strokes apply to |
| inc_o | output | 1 | Increment stroke, one cycle |
| dec_o | output | 1 | Decrement stroke, one cycle |

## Verification
Two events can meet in one cycle: the mode-ending STOP and a fresh enable from the front end. The bench provokes this directly. It raises SCL with SDA low on an open session, then raises SDA together with a one-cycle `step_en_i` carrying a different pot index. It judges the outcome at the ports: `active_o` must stay set, and `pot_o` must switch to the new index. A second overlap is also driven. A STOP lands inside the high period of a clock pulse, and the bench confirms that only that pulse's stroke is counted.

// File: rtl/wiper_step_engine.sv
module wiper_step_engine #(
  parameter int TAP_BITS = 6,
  parameter int POT_BITS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                step_en_i,
  input  logic [POT_BITS-1:0] pot_i,
  input  logic [TAP_BITS-1:0] wiper_i,
  output logic                active_o,
  output logic [POT_BITS-1:0] pot_o,
  output logic                inc_o,
  output logic                dec_o
);
  localparam logic [TAP_BITS-1:0] TOP_TAP = '1;
  localparam logic [TAP_BITS-1:0] LOW_TAP = '0;

  logic scl_q, sda_q;
  logic scl_rise, stop_seen, at_top, at_low;

  assign scl_rise  = scl_i & ~scl_q;
  assign stop_seen = scl_i & scl_q & sda_i & ~sda_q;
  assign at_top    = (wiper_i == TOP_TAP);
  assign at_low    = (wiper_i == LOW_TAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      active_o <= 1'b0;
      pot_o    <= '0;
      inc_o    <= 1'b0;
      dec_o    <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      inc_o <= active_o & scl_rise &  sda_i & ~at_top;
      dec_o <= active_o & scl_rise & ~sda_i & ~at_low;
      if (step_en_i) begin
        active_o <= 1'b1;
        pot_o    <= pot_i;
      end else if (stop_seen) begin
        active_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wiper_step_engine_chk.sv
module wiper_step_engine_chk #(
  parameter int TAP_BITS = 6,
  parameter int POT_BITS = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_i,
  input logic                sda_i,
  input logic                step_en_i,
  input logic [POT_BITS-1:0] pot_i,
  input logic [TAP_BITS-1:0] wiper_i,
  input logic                active_o,
  input logic [POT_BITS-1:0] pot_o,
  input logic                inc_o,
  input logic                dec_o
);
  localparam logic [TAP_BITS-1:0] TOP_TAP = '1;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!active_o && !inc_o && !dec_o));

  p_enable_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_i |=> (active_o && pot_o == $past(pot_i)));

  p_inc_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inc_o |=> !inc_o);

  p_dec_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_o |=> !dec_o);

  p_no_inc_at_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_o |-> $past(wiper_i) != TOP_TAP);

  p_no_dec_at_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_o |-> $past(wiper_i) != '0);

  p_stop_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !step_en_i && scl_i && $past(scl_i) && sda_i && !$past(sda_i))
      |=> !active_o);

  p_high_period_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |=> (!inc_o && !dec_o));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_o || dec_o) |-> $past(active_o));

  p_stroke_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_o && dec_o));
endmodule

bind wiper_step_engine wiper_step_engine_chk #(
  .TAP_BITS(TAP_BITS), .POT_BITS(POT_BITS)
) u_chk (.*);

// File: tb/wiper_step_engine_test.sv
`timescale 1ns/1ps
module wiper_step_engine_test;
  localparam int TB = 6;
  localparam int PB = 1;
  localparam int NV = 8;

  // {start[26:21], dir[20], pulses[19:13], end[12:7], incs[6:0]}
  // every run is closed by a STOP whose clock rise carries SDA low
  localparam logic [26:0] VEC [NV] = '{
    {6'd10, 1'b1, 7'd5,  6'd14, 7'd5},
    {6'd10, 1'b0, 7'd4,  6'd5,  7'd0},
    {6'd60, 1'b1, 7'd7,  6'd62, 7'd3},
    {6'd3,  1'b0, 7'd9,  6'd0,  7'd0},
    {6'd0,  1'b1, 7'd70, 6'd62, 7'd63},
    {6'd63, 1'b0, 7'd64, 6'd0,  7'd0},
    {6'd62, 1'b1, 7'd1,  6'd62, 7'd1},
    {6'd1,  1'b0, 7'd1,  6'd0,  7'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, en = 1'b0;
  logic [PB-1:0] pot = '0;
  logic [TB-1:0] wmodel;
  logic load = 1'b0, clr = 1'b0;
  logic [TB-1:0] load_val = '0;
  logic active, inc, dec;
  logic [PB-1:0] pot_out;
  int inc_cnt, dec_cnt, both_seen;
  int total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk;

  wiper_step_engine #(.TAP_BITS(TB), .POT_BITS(PB)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .step_en_i(en),
    .pot_i(pot), .wiper_i(wmodel), .active_o(active), .pot_o(pot_out),
    .inc_o(inc), .dec_o(dec));

  always @(posedge clk) begin
    if (load) wmodel <= load_val;
    else if (inc) wmodel <= wmodel + 1'b1;
    else if (dec) wmodel <= wmodel - 1'b1;
    if (clr) begin inc_cnt <= 0; dec_cnt <= 0; end
    else begin
      if (inc) inc_cnt <= inc_cnt + 1;
      if (dec) dec_cnt <= dec_cnt + 1;
    end
    if (inc && dec) both_seen <= both_seen + 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic preset(input logic [TB-1:0] v);
    @(negedge clk); load = 1'b1; load_val = v; clr = 1'b1;
    @(negedge clk); load = 1'b0; clr = 1'b0;
  endtask

  task automatic enable(input logic [PB-1:0] p);
    @(negedge clk); en = 1'b1; pot = p;
    @(negedge clk); en = 1'b0;
  endtask

  task automatic pulse(input logic d, input int high_len);
    @(negedge clk); scl = 1'b0;
    @(negedge clk); sda = d;
    idle(2); scl = 1'b1;
    idle(high_len); scl = 1'b0;
    idle(2);
  endtask

  task automatic stop_cond();
    @(negedge clk); scl = 1'b0;
    @(negedge clk); sda = 1'b0;
    idle(2); scl = 1'b1;
    idle(2); sda = 1'b1;
    idle(3);
  endtask

  initial begin
    inc_cnt = 0; dec_cnt = 0; both_seen = 0; wmodel = '0;
    idle(4);
    check("R1 active after reset", active, 0);
    check("R1 inc after reset", inc, 0);
    check("R1 dec after reset", dec, 0);
    rst_n = 1'b1;
    idle(2);

    for (int i = 0; i < NV; i++) begin
      preset(VEC[i][26:21]);
      enable(1'b0);
      for (int k = 0; k < int'(VEC[i][19:13]); k++) pulse(VEC[i][20], 3);
      stop_cond();
      check($sformatf("R3 R4 R5 final tap vec%0d", i), wmodel, VEC[i][12:7]);
      check($sformatf("R3 R5 increment count vec%0d", i), inc_cnt, VEC[i][6:0]);
    end

    // R8: no strokes while idle
    preset(6'd20);
    pulse(1'b1, 3); pulse(1'b0, 3); pulse(1'b1, 3);
    check("R8 idle strokes", inc_cnt + dec_cnt, 0);
    check("R8 idle tap", wmodel, 20);

    // R2: capture of pot index
    enable(1'b1);
    @(negedge clk); pot = 1'b0;
    idle(2);
    check("R2 active set", active, 1);
    check("R2 pot held", pot_out, 1);

    // R3: long high period still gives one stroke
    preset(6'd20);
    pulse(1'b1, 12);
    check("R3 one stroke per edge", inc_cnt, 1);
    check("R3 tap", wmodel, 21);

    // R7: STOP inside a high period, only the pulse's own stroke
    @(negedge clk); scl = 1'b0;
    @(negedge clk); sda = 1'b0;
    idle(2); scl = 1'b1;
    idle(3); sda = 1'b1;
    idle(3);
    check("R7 strokes around STOP", dec_cnt, 1);
    check("R6 closed by STOP", active, 0);

    // R6: no strokes after close
    pulse(1'b1, 3); pulse(1'b0, 3);
    check("R6 no strokes after STOP", inc_cnt + dec_cnt - 2, 0);

    // R9: enable and STOP in the same cycle
    enable(1'b1);
    @(negedge clk); scl = 1'b0;
    @(negedge clk); sda = 1'b0;
    idle(2); scl = 1'b1;
    idle(2); sda = 1'b1; en = 1'b1; pot = 1'b0;
    @(negedge clk); en = 1'b0;
    idle(2);
    check("R9 enable wins active", active, 1);
    check("R9 enable wins pot", pot_out, 0);
    stop_cond();
    check("R6 final close", active, 0);

    check("R10 never both strokes", both_seen, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule